// File: doc/BRIEF.md
# Dual Tone and Carrier Generator

This block holds two independent 8-bit reload down-counters, called channel A and channel B. Each counter is fed by its own prescaler, which divides the CPU clock by a power of two between 2 and 256. A mode field for each channel selects what the channel does. It can be idle, act as a periodic timer that pulses an interrupt request, or drive a square-wave tone bit for a sound path.

Channel B has one more use. It can serve as a carrier clock that is inserted into a port pin's output. The insertion happens only while that pin's data value equals a programmable polarity bit. At all other times the pin output simply follows the pin's data. Software programs the block through a write-only register bus with four addresses. Every output is registered.

Top module: `dual_tone_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all five outputs are 0. Reset sets every register field to zero, so both channels start disabled.
- R2: The divider field sits at address 0. Channel A uses bits 2:0 and channel B uses bits 6:4. A field value k gives one prescaled tick every 2^(k+1) CPU clocks. A tick is never asserted in two consecutive cycles.
- R3: An enabled counter steps down by one on each tick. On the tick where it reads zero, it expires and reloads its load value. An expiry therefore happens every (N+1) ticks, where N is the load value. The load value for channel A is at address 1 and for channel B at address 2.
- R4: In tone mode the tone output toggles at every expiry. With divider field k and load value N, the output's half period is 2^(k+1)*(N+1) clocks.
- R5: Channel A's mode is address 3, bits 1:0. Value 00 or 10 disables the channel, 01 selects timer and 11 selects tone. A disabled channel holds its counter at the load value and clears its tone state. tone_a_o is 0 unless the mode is tone. irq_a_o is 0 unless the mode is timer.
- R6: Channel B's mode is address 3, bits 3:2. Value 00 disables the channel, 01 selects timer, 10 selects carrier and 11 selects tone. tone_b_o is 0 unless the mode is tone. irq_b_o is 0 unless the mode is timer.
- R7: Address 3, bit 7 is the carrier polarity. In carrier mode, pin_o carries channel B's square wave while port_bit_i equals the polarity bit. Otherwise pin_o equals port_bit_i, delayed by one register.
- R8: A write to a load register does not change the count in progress. The new value is first used at the next reload.
- R9: Each timer-mode expiry produces exactly one single-cycle high pulse on that channel's interrupt output.
- R10: The write that enables a channel restarts its prescaler. The first expiry output then appears 2^(k+1)*(N+1) clocks after the clock edge that accepted that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 divider, 1 load A, 2 load B, 3 mode) |
| wr_data | input | 8 | Register write data |
| port_bit_i | input | 1 | Data value of the port pin that can receive the carrier |
| tone_a_o | output | 1 | Channel A tone bit |
| tone_b_o | output | 1 | Channel B tone bit |
| pin_o | output | 1 | Port pin output, with the carrier inserted when it is enabled |
| irq_a_o | output | 1 | Channel A timer interrupt pulse |
| irq_b_o | output | 1 | Channel B timer interrupt pulse |

## Verification
The hardest case to reach from the ports is a reload value written while a count is already running. To hit the window that R8 is about, the stimulus waits until an interrupt pulse is seen. It then writes the new load value on the next edge, which falls after the old value has already been reloaded. The next interval must still follow the old value, and only the one after it may follow the new value. A divider change in the middle of a run leaves the prescaler phase arbitrary. For that reason the first toggle after the change is discarded, and only the intervals after it are compared.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_DIV   = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOADA = 2'd1;
  localparam logic [ADDR_W-1:0] A_LOADB = 2'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd3;

  typedef enum logic [1:0] {
    MB_OFF     = 2'b00,
    MB_TIMER   = 2'b01,
    MB_CARRIER = 2'b10,
    MB_TONE    = 2'b11
  } mode_b_t;

  localparam logic [1:0] MA_TIMER = 2'b01;
  localparam logic [1:0] MA_TONE  = 2'b11;
endpackage

// File: rtl/tgen_presc.sv
module tgen_presc #(
  parameter int SEL_W = 3,
  parameter int PRE_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int SH_W = SEL_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_w;
  logic [PRE_W:0]   mask_w;
  logic [SH_W-1:0]  shamt;
  logic [PRE_W-1:0] mask;

  assign one_w  = {{PRE_W{1'b0}}, 1'b1};
  assign shamt  = {1'b0, sel} + {{(SH_W-1){1'b0}}, 1'b1};
  assign mask_w = (one_w << shamt) - one_w;
  assign mask   = mask_w[PRE_W-1:0];
  assign tick   = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tgen_chan.sv
module tgen_chan #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] load,
  output logic             expire,
  output logic             wave
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q;

  tgen_presc #(.SEL_W(SEL_W)) u_presc (
    .clk (clk),
    .rst (rst),
    .run (run),
    .sel (sel),
    .tick(tick)
  );

  assign expire = run && tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= load;
      wave  <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q <= load;
        wave  <= ~wave;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_reload_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(load)));
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
  p_wave_only_on_expiry_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !expire) |=> $stable(wave));
endmodule

// File: rtl/tgen_regs.sv
module tgen_regs
  import tgen_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b,
  output logic [CNT_W-1:0]  load_a,
  output logic [CNT_W-1:0]  load_b,
  output logic [1:0]        mode_a,
  output logic [1:0]        mode_b,
  output logic              pol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a  <= '0;
      sel_b  <= '0;
      load_a <= '0;
      load_b <= '0;
      mode_a <= '0;
      mode_b <= '0;
      pol    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIV: begin
          sel_a <= wr_data[SEL_W-1:0];
          sel_b <= wr_data[4 +: SEL_W];
        end
        A_LOADA: load_a <= wr_data[CNT_W-1:0];
        A_LOADB: load_b <= wr_data[CNT_W-1:0];
        default: begin
          mode_a <= wr_data[1:0];
          mode_b <= wr_data[3:2];
          pol    <= wr_data[7];
        end
      endcase
    end
  end

  p_mode_reset_r1: assert property (@(posedge clk)
    rst |=> (mode_a == 2'b00 && mode_b == 2'b00));
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen
  import tgen_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              port_bit_i,
  output logic              tone_a_o,
  output logic              tone_b_o,
  output logic              pin_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int NCH = 2;

  logic [SEL_W-1:0] sel_a, sel_b;
  logic [CNT_W-1:0] load_a, load_b;
  logic [1:0]       mode_a, mode_b;
  logic             pol;

  logic [SEL_W-1:0] ch_sel  [NCH];
  logic [CNT_W-1:0] ch_load [NCH];
  logic [NCH-1:0]   ch_run, ch_exp, ch_wave;

  tgen_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_a(sel_a), .sel_b(sel_b), .load_a(load_a), .load_b(load_b),
    .mode_a(mode_a), .mode_b(mode_b), .pol(pol)
  );

  assign ch_sel[0]  = sel_a;
  assign ch_sel[1]  = sel_b;
  assign ch_load[0] = load_a;
  assign ch_load[1] = load_b;
  assign ch_run[0]  = mode_a[0];
  assign ch_run[1]  = |mode_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tgen_chan #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .run   (ch_run[g]),
      .sel   (ch_sel[g]),
      .load  (ch_load[g]),
      .expire(ch_exp[g]),
      .wave  (ch_wave[g])
    );
  end

  logic carrier_on;
  assign carrier_on = (mode_b == MB_CARRIER) && (port_bit_i == pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_a_o <= 1'b0;
      tone_b_o <= 1'b0;
      pin_o    <= 1'b0;
      irq_a_o  <= 1'b0;
      irq_b_o  <= 1'b0;
    end else begin
      tone_a_o <= (mode_a == MA_TONE) && ch_wave[0];
      tone_b_o <= (mode_b == MB_TONE) && ch_wave[1];
      irq_a_o  <= (mode_a == MA_TIMER) && ch_exp[0];
      irq_b_o  <= (mode_b == MB_TIMER) && ch_exp[1];
      pin_o    <= carrier_on ? ch_wave[1] : port_bit_i;
    end
  end

  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq_a_o |=> !irq_a_o);
  p_irqb_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq_b_o |=> !irq_b_o);
  p_tone_a_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_a != MA_TONE) |=> !tone_a_o);
  p_irq_b_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_b != MB_TIMER) |=> !irq_b_o);
  p_pin_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_b != MB_CARRIER) |=> (pin_o == $past(port_bit_i)));
endmodule

// File: tb/dual_tone_gen_test.sv
module dual_tone_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       port_bit_i = 1'b0;
  logic       tone_a_o, tone_b_o, pin_o, irq_a_o, irq_b_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit started = 0;

  always #10 clk = ~clk;

  dual_tone_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .port_bit_i(port_bit_i), .tone_a_o(tone_a_o), .tone_b_o(tone_b_o),
    .pin_o(pin_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated at every rising edge
  int  m_sel[2], m_load[2], m_pre[2], m_cnt[2], m_wave[2];
  int  m_mode_a, m_mode_b, m_pol;
  bit  m_tone_a, m_tone_b, m_pin, m_irq_a, m_irq_b;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_sel[c] = 0; m_load[c] = 0; m_pre[c] = 0; m_cnt[c] = 0; m_wave[c] = 0;
      end
      m_mode_a = 0; m_mode_b = 0; m_pol = 0;
      m_tone_a = 0; m_tone_b = 0; m_pin = 0; m_irq_a = 0; m_irq_b = 0;
    end else begin
      bit en[2], tk[2], ex[2];
      en[0] = (m_mode_a % 2) == 1;
      en[1] = m_mode_b != 0;
      for (int c = 0; c < 2; c++) begin
        int div;
        div = 2 << m_sel[c];
        tk[c] = en[c] && ((m_pre[c] % div) == div - 1);
        ex[c] = tk[c] && (m_cnt[c] == 0);
      end
      m_irq_a  = (m_mode_a == 1) && ex[0];
      m_irq_b  = (m_mode_b == 1) && ex[1];
      m_tone_a = (m_mode_a == 3) && (m_wave[0] != 0);
      m_tone_b = (m_mode_b == 3) && (m_wave[1] != 0);
      if (m_mode_b == 2 && int'(port_bit_i) == m_pol) m_pin = (m_wave[1] != 0);
      else m_pin = port_bit_i;
      for (int c = 0; c < 2; c++) begin
        if (!en[c]) begin
          m_pre[c] = 0; m_cnt[c] = m_load[c]; m_wave[c] = 0;
        end else begin
          m_pre[c] = (m_pre[c] + 1) % 256;
          if (tk[c]) begin
            if (m_cnt[c] == 0) begin
              m_cnt[c] = m_load[c]; m_wave[c] = 1 - m_wave[c];
            end else m_cnt[c] = m_cnt[c] - 1;
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_sel[0] = wr_data[2:0]; m_sel[1] = wr_data[6:4]; end
          2'd1: m_load[0] = wr_data;
          2'd2: m_load[1] = wr_data;
          default: begin
            m_mode_a = wr_data[1:0]; m_mode_b = wr_data[3:2]; m_pol = wr_data[7];
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(irq_a_o == m_irq_a, "R3 irq_a_o vs model", irq_a_o, m_irq_a);
      check(irq_b_o == m_irq_b, "R6 irq_b_o vs model", irq_b_o, m_irq_b);
      check(tone_a_o == m_tone_a, "R5 tone_a_o vs model", tone_a_o, m_tone_a);
      check(tone_b_o == m_tone_b, "R4 tone_b_o vs model", tone_b_o, m_tone_b);
      check(pin_o == m_pin, "R7 pin_o vs model", pin_o, m_pin);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gap_irq_a(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_a_o && n < 5000);
  endtask

  task automatic gap_irq_b(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_b_o && n < 5000);
  endtask

  task automatic gap_tone_b(output int n);
    logic prev;
    prev = tone_b_o;
    n = 0;
    do begin @(negedge clk); n++; end while (tone_b_o == prev && n < 5000);
  endtask

  task automatic count_pin(input int cycles, output int toggles, output int highs);
    logic prev;
    prev = pin_o; toggles = 0; highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pin_o != prev) toggles++;
      if (pin_o) highs++;
      prev = pin_o;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, t, h, cnt_irq, cnt_tone;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({tone_a_o, tone_b_o, pin_o, irq_a_o, irq_b_o} == 5'b0, "R1 outputs in reset",
          {tone_a_o, tone_b_o, pin_o, irq_a_o, irq_b_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({tone_a_o, tone_b_o, pin_o, irq_a_o, irq_b_o} == 5'b0, "R1 outputs after release",
          {tone_a_o, tone_b_o, pin_o, irq_a_o, irq_b_o}, 0);
    started = 1;

    // R10 / R3 / R9: channel A timer, divide 2, load 3
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd3);
    wr(2'd3, 8'h01);
    gap_irq_a(n);
    check(n == 8, "R10 first expiry delay", n, 8);
    gap_irq_a(n);
    check(n == 8, "R3 timer period", n, 8);
    @(negedge clk);
    check(irq_a_o == 1'b0, "R9 pulse width one cycle", irq_a_o, 0);
    gap_irq_a(n);
    check(n == 7, "R9 next pulse spacing", n, 7);

    // R8: new load written right after a reload
    wr(2'd1, 8'd9);
    gap_irq_a(n);
    check(n == 7, "R8 count in progress undisturbed", n, 7);
    gap_irq_a(n);
    check(n == 20, "R8 new load used after reload", n, 20);

    // R5: mode 10 disables channel A
    wr(2'd3, 8'h02);
    cnt_irq = 0; cnt_tone = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq_a_o) cnt_irq++;
      if (tone_a_o) cnt_tone++;
    end
    check(cnt_irq == 0 && cnt_tone == 0, "R5 mode 10 silent", cnt_irq + cnt_tone, 0);

    // R4 / R2: channel B tone, divide 4, load 2
    wr(2'd0, 8'h10);
    wr(2'd2, 8'd2);
    wr(2'd3, 8'h0C);
    gap_tone_b(n);
    gap_tone_b(n);
    check(n == 12, "R4 tone half period", n, 12);
    gap_tone_b(n);
    check(n == 12, "R4 tone half period repeat", n, 12);

    // R2: channel B divider from bits 6:4 (divide 16), load 1
    wr(2'd0, 8'h30);
    wr(2'd2, 8'd1);
    gap_tone_b(n);
    gap_tone_b(n);
    gap_tone_b(n);
    check(n == 32, "R2 divider field bits 6:4", n, 32);

    // R7: carrier, polarity 1
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h88);
    port_bit_i = 1'b1;
    @(negedge clk);
    count_pin(40, t, h);
    check(t >= 8, "R7 carrier inserted while pin high", t, 8);
    port_bit_i = 1'b0;
    @(negedge clk);
    count_pin(30, t, h);
    check(t == 0 && h == 0, "R7 no carrier while pin low", t + h, 0);
    // polarity 0
    wr(2'd3, 8'h08);
    @(negedge clk);
    count_pin(40, t, h);
    check(t >= 8, "R7 carrier inserted while pin low", t, 8);
    port_bit_i = 1'b1;
    @(negedge clk);
    count_pin(30, t, h);
    check(t == 0 && h == 30, "R7 pin follows data when high", h, 30);

    // R6: channel B timer, divide 2, load 1
    wr(2'd3, 8'h04);
    gap_irq_b(n);
    gap_irq_b(n);
    check(n == 4, "R6 channel B timer period", n, 4);
    wr(2'd3, 8'h00);
    cnt_irq = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_b_o) cnt_irq++;
    end
    check(cnt_irq == 0, "R6 mode 00 no interrupt", cnt_irq, 0);
    check(pin_o == port_bit_i, "R6 pin passes when off", pin_o, port_bit_i);

    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule